// File: doc/BRIEF.md
# TDM B-Channel Bit Mask Unit

This unit sits between a time-division serial frame and a byte-oriented channel engine. The frame carries two 8-bit bearer slots, B1 and B2. A 16-bit mask register selects which bit times of each slot carry data. A bit time with its mask bit set is captured on receive and driven on transmit. A bit time with its mask bit clear is skipped in both directions. The slot strobes always cover the whole slot, whatever the mask holds.

Frame timing comes in on two inputs. `slot_vld_i` is one-hot and stays high for the whole slot. `bit_stb_i` pulses once for each bit time. On transmit, the unit samples the slot's byte at the slot's first bit time. It then shifts that byte out LSB first, moving on only at unmasked bit times. On receive, it packs the unmasked bits downward into a byte. It reports the byte as soon as the last unmasked bit of the slot has arrived. A mask written while a slot is running does not take effect until the next slot boundary.

Top module: `tdm_bmask`

## Requirements
- R1: The mask register resets to all ones. In the cycle after a write, `reg_rdata_o` returns the value written.
- R2: Mask bits 7:0 cover slot B1 (`slot_vld_i[0]`) and bits 15:8 cover slot B2 (`slot_vld_i[1]`). Within each byte, bit 0 is the first bit time of the slot.
- R3: `sd_o[k]` is high in every cycle in which `slot_vld_i[k]` is high, for every mask value. `rx_cap_o` is only high in a cycle with `bit_stb_i` high inside a slot.
- R4: In a masked-off bit time, `rx_cap_o` and `tx_drv_o` are 0 and `tx_data_o` is 1. No bit is captured.
- R5: In an unmasked bit time (the `bit_stb_i` cycle), `rx_cap_o` and `tx_drv_o` are both 1. `tx_data_o` carries the next unsent bit of the slot's transmit byte, LSB first. The transmit shifter advances only on unmasked bit times.
- R6: Unmasked receive bits are packed from bit 0 upward in arrival order. `rx_valid_o` pulses for one cycle, in the cycle after the slot's last unmasked bit, with `rx_byte_o`, `rx_len_o` (the count of packed bits) and `rx_ch_o` (0 = B1, 1 = B2).
- R7: A slot whose mask byte is all zero produces no `rx_valid_o`.
- R8: A slot uses the mask held at its first bit time. A write in that cycle or later in the slot applies from the next slot on.
- R9: The transmit byte `tx_byte_i[8k+7:8k]` is sampled at the first bit time of slot k. Later changes within the slot have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Mask register write enable |
| reg_wdata_i | input | 16 | Mask write data |
| reg_rdata_o | output | 16 | Mask register read data |
| bit_stb_i | input | 1 | One pulse per bit time |
| slot_vld_i | input | 2 | One-hot slot active (bit 0 = B1, bit 1 = B2) |
| sd_o | output | 2 | Per-slot serial data strobes |
| rx_data_i | input | 1 | Serial receive line |
| rx_cap_o | output | 1 | Receive capture enable for this bit time |
| tx_byte_i | input | 16 | Transmit bytes, B1 in 7:0, B2 in 15:8 |
| tx_data_o | output | 1 | Serial transmit line, idles at 1 |
| tx_drv_o | output | 1 | Transmit drive enable for this bit time |
| rx_valid_o | output | 1 | Received byte complete (one-cycle pulse) |
| rx_byte_o | output | 8 | Packed received bits |
| rx_len_o | output | 4 | Number of packed bits |
| rx_ch_o | output | 1 | Slot of the completed byte |

## Verification
The strobes, `rx_cap_o`, `tx_drv_o` and `tx_data_o` follow from the current inputs in the same cycle. The bench drives each bit time at a falling edge and samples these outputs 1 ns later, inside that same cycle. The mask readback and `rx_valid_o` come from registers, so they appear one clock after the write or after the last unmasked bit. The bench records the cycle number of every unmasked bit. A monitor stamps each valid pulse with its cycle number, and the bench checks that the two numbers differ by exactly one. Mask writes are placed at the first bit time and in the middle of a slot, so the one-slot delay of a mask change is seen at the ports.

// File: rtl/tdm_bmask_pkg.sv
package tdm_bmask_pkg;
  localparam int unsigned CH_W_DEF = 8;
  localparam int unsigned N_CH_DEF = 2;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tdm_bmask_regs.sv
module tdm_bmask_regs #(
  parameter int unsigned MASK_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [MASK_W-1:0] wdata_i,
  output logic [MASK_W-1:0] mask_o
);
  logic [MASK_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '1;
    else if (we_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/tdm_bmask_slot.sv
module tdm_bmask_slot #(
  parameter int unsigned CH_W  = 8,
  parameter int unsigned N_CH  = 2,
  parameter int unsigned POS_W = 3,
  parameter int unsigned IDX_W = 1,
  localparam int unsigned MASK_W = CH_W * N_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_stb_i,
  input  logic [N_CH-1:0]   slot_vld_i,
  input  logic [MASK_W-1:0] mask_i,
  output logic [N_CH-1:0]   sd_o,
  output logic              bit_act_o,
  output logic              first_o,
  output logic              bit_on_o,
  output logic              last_on_o,
  output logic [IDX_W-1:0]  ch_o
);
  logic [POS_W-1:0]  cnt_q;
  logic [MASK_W-1:0] act_q, eff_mask;
  logic [CH_W-1:0]   cur_byte;
  logic              in_slot, any_above;
  logic [IDX_W-1:0]  ch;

  assign in_slot = |slot_vld_i;
  assign sd_o    = slot_vld_i;

  // lowest active slot wins if the one-hot rule is broken
  always_comb begin
    ch = '0;
    for (int k = N_CH - 1; k >= 0; k--)
      if (slot_vld_i[k]) ch = IDX_W'(k);
  end

  // mask is taken fresh only at a slot boundary
  assign eff_mask = (cnt_q == '0) ? mask_i : act_q;
  assign cur_byte = eff_mask[ch*CH_W +: CH_W];

  always_comb begin
    any_above = 1'b0;
    for (int j = 0; j < int'(CH_W); j++)
      if (j > int'(cnt_q) && cur_byte[j]) any_above = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= '1;
    end else begin
      act_q <= eff_mask;
      if (!in_slot)
        cnt_q <= '0;
      else if (bit_stb_i)
        cnt_q <= (cnt_q == POS_W'(CH_W - 1)) ? '0 : cnt_q + 1'b1;
    end
  end

  assign bit_act_o = bit_stb_i & in_slot;
  assign first_o   = (cnt_q == '0);
  assign bit_on_o  = cur_byte[cnt_q];
  assign last_on_o = cur_byte[cnt_q] & ~any_above;
  assign ch_o      = ch;
endmodule

// File: rtl/tdm_bmask_tx.sv
module tdm_bmask_tx #(
  parameter int unsigned CH_W  = 8,
  parameter int unsigned N_CH  = 2,
  parameter int unsigned IDX_W = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bit_act_i,
  input  logic                 first_i,
  input  logic                 bit_on_i,
  input  logic [IDX_W-1:0]     ch_i,
  input  logic [CH_W*N_CH-1:0] tx_byte_i,
  output logic                 tx_data_o,
  output logic                 tx_drv_o
);
  logic [CH_W-1:0] sh_q, cur;

  assign cur       = first_i ? tx_byte_i[ch_i*CH_W +: CH_W] : sh_q;
  assign tx_drv_o  = bit_act_i & bit_on_i;
  assign tx_data_o = tx_drv_o ? cur[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sh_q <= '1;
    else if (bit_act_i) sh_q <= bit_on_i ? {1'b1, cur[CH_W-1:1]} : cur;
  end
endmodule

// File: rtl/tdm_bmask_rx.sv
module tdm_bmask_rx #(
  parameter int unsigned CH_W  = 8,
  parameter int unsigned LEN_W = 4,
  parameter int unsigned IDX_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_act_i,
  input  logic             first_i,
  input  logic             bit_on_i,
  input  logic             last_on_i,
  input  logic [IDX_W-1:0] ch_i,
  input  logic             rx_data_i,
  output logic             rx_cap_o,
  output logic             rx_valid_o,
  output logic [CH_W-1:0]  rx_byte_o,
  output logic [LEN_W-1:0] rx_len_o,
  output logic [IDX_W-1:0] rx_ch_o
);
  logic [CH_W-1:0]  asm_q, base_asm, new_asm;
  logic [LEN_W-1:0] n_q, base_n, new_n;
  logic             valid_q;
  logic [CH_W-1:0]  byte_q;
  logic [LEN_W-1:0] len_q;
  logic [IDX_W-1:0] ch_q;

  assign rx_cap_o = bit_act_i & bit_on_i;
  assign base_n   = first_i ? '0 : n_q;
  assign base_asm = first_i ? '0 : asm_q;
  assign new_n    = base_n + LEN_W'(rx_cap_o);

  always_comb begin
    new_asm = base_asm;
    for (int j = 0; j < int'(CH_W); j++)
      if (rx_cap_o && base_n == LEN_W'(j)) new_asm[j] = rx_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asm_q   <= '0;
      n_q     <= '0;
      valid_q <= 1'b0;
      byte_q  <= '0;
      len_q   <= '0;
      ch_q    <= '0;
    end else begin
      valid_q <= 1'b0;
      if (bit_act_i) begin
        asm_q <= new_asm;
        n_q   <= new_n;
        if (rx_cap_o && last_on_i) begin
          valid_q <= 1'b1;
          byte_q  <= new_asm;
          len_q   <= new_n;
          ch_q    <= ch_i;
        end
      end
    end
  end

  assign rx_valid_o = valid_q;
  assign rx_byte_o  = byte_q;
  assign rx_len_o   = len_q;
  assign rx_ch_o    = ch_q;
endmodule

// File: rtl/tdm_bmask.sv
module tdm_bmask
  import tdm_bmask_pkg::*;
#(
  parameter int unsigned CH_W = CH_W_DEF,
  parameter int unsigned N_CH = N_CH_DEF,
  localparam int unsigned MASK_W = CH_W * N_CH,
  localparam int unsigned POS_W  = idx_w(CH_W),
  localparam int unsigned IDX_W  = idx_w(N_CH),
  localparam int unsigned LEN_W  = $clog2(CH_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [MASK_W-1:0] reg_wdata_i,
  output logic [MASK_W-1:0] reg_rdata_o,
  input  logic              bit_stb_i,
  input  logic [N_CH-1:0]   slot_vld_i,
  output logic [N_CH-1:0]   sd_o,
  input  logic              rx_data_i,
  output logic              rx_cap_o,
  input  logic [MASK_W-1:0] tx_byte_i,
  output logic              tx_data_o,
  output logic              tx_drv_o,
  output logic              rx_valid_o,
  output logic [CH_W-1:0]   rx_byte_o,
  output logic [LEN_W-1:0]  rx_len_o,
  output logic [IDX_W-1:0]  rx_ch_o
);
  logic [MASK_W-1:0] mask;
  logic              bit_act, first, bit_on, last_on;
  logic [IDX_W-1:0]  ch;

  tdm_bmask_regs #(.MASK_W(MASK_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .mask_o  (mask)
  );

  assign reg_rdata_o = mask;

  tdm_bmask_slot #(.CH_W(CH_W), .N_CH(N_CH), .POS_W(POS_W), .IDX_W(IDX_W)) u_slot (
    .clk_i, .rst_ni,
    .bit_stb_i,
    .slot_vld_i,
    .mask_i    (mask),
    .sd_o,
    .bit_act_o (bit_act),
    .first_o   (first),
    .bit_on_o  (bit_on),
    .last_on_o (last_on),
    .ch_o      (ch)
  );

  tdm_bmask_tx #(.CH_W(CH_W), .N_CH(N_CH), .IDX_W(IDX_W)) u_tx (
    .clk_i, .rst_ni,
    .bit_act_i (bit_act),
    .first_i   (first),
    .bit_on_i  (bit_on),
    .ch_i      (ch),
    .tx_byte_i,
    .tx_data_o,
    .tx_drv_o
  );

  tdm_bmask_rx #(.CH_W(CH_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_rx (
    .clk_i, .rst_ni,
    .bit_act_i (bit_act),
    .first_i   (first),
    .bit_on_i  (bit_on),
    .last_on_i (last_on),
    .ch_i      (ch),
    .rx_data_i,
    .rx_cap_o,
    .rx_valid_o,
    .rx_byte_o,
    .rx_len_o,
    .rx_ch_o
  );
endmodule

// File: rtl/tdm_bmask_chk.sv
module tdm_bmask_chk #(
  parameter int unsigned CH_W   = 8,
  parameter int unsigned N_CH   = 2,
  parameter int unsigned LEN_W  = 4,
  localparam int unsigned MASK_W = CH_W * N_CH
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [MASK_W-1:0] reg_wdata_i,
  input logic [MASK_W-1:0] reg_rdata_o,
  input logic              bit_stb_i,
  input logic [N_CH-1:0]   sd_o,
  input logic              rx_cap_o,
  input logic              tx_drv_o,
  input logic              tx_data_o,
  input logic              rx_valid_o,
  input logic [LEN_W-1:0]  rx_len_o
);
  always @(negedge clk_i)
    if (!rst_ni)
      assert_reset_ones_R1: assert (reg_rdata_o == '1) else $error("mask not all ones in reset");

  assert_write_readback_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> reg_rdata_o == $past(reg_wdata_i));

  assert_cap_in_slot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cap_o |-> (bit_stb_i && sd_o != '0));

  assert_idle_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_drv_o |-> tx_data_o);

  assert_dir_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cap_o == tx_drv_o);

  assert_len_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> (rx_len_o != '0 && rx_len_o <= LEN_W'(CH_W)));
endmodule

bind tdm_bmask tdm_bmask_chk #(.CH_W(CH_W), .N_CH(N_CH), .LEN_W(LEN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .bit_stb_i   (bit_stb_i),
  .sd_o        (sd_o),
  .rx_cap_o    (rx_cap_o),
  .tx_drv_o    (tx_drv_o),
  .tx_data_o   (tx_data_o),
  .rx_valid_o  (rx_valid_o),
  .rx_len_o    (rx_len_o)
);

// File: tb/tdm_bmask_bench.sv
`timescale 1ns/1ps
module tdm_bmask_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic        bit_stb_i = 1'b0;
  logic [1:0]  slot_vld_i = '0;
  logic [1:0]  sd_o;
  logic        rx_data_i = 1'b0;
  logic        rx_cap_o;
  logic [15:0] tx_byte_i = '0;
  logic        tx_data_o, tx_drv_o;
  logic        rx_valid_o;
  logic [7:0]  rx_byte_o;
  logic [3:0]  rx_len_o;
  logic [0:0]  rx_ch_o;

  int checks = 0, fails = 0, cyc = 0;
  int v_cnt = 0, v_cyc = 0, v_len = 0, v_ch = 0;
  logic [7:0]  v_byte = '0;
  logic [15:0] model = 16'hFFFF;
  bit done = 0;

  tdm_bmask u_tdm_bmask (.*);

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i)
    if (rx_valid_o) begin
      v_cnt++; v_cyc = cyc; v_byte = rx_byte_o; v_len = rx_len_o; v_ch = rx_ch_o;
    end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic write_mask(input logic [15:0] v);
    @(negedge clk_i); reg_we_i = 1'b1; reg_wdata_i = v;
    @(negedge clk_i); reg_we_i = 1'b0;
    #1 chk("R1", "readback", reg_rdata_o, v);
    model = v;
  endtask

  task automatic run_slot(input int ch, input logic [7:0] tx, input logic [7:0] rx,
                          input int wr_at, input logic [15:0] wr_val, input logic [7:0] tx_late);
    logic [7:0] m, exp_rx;
    int k, n, last_c, v0;
    m = model[ch*8 +: 8]; k = 0; n = 0; exp_rx = '0; last_c = -1; v0 = v_cnt;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      if (i == 0) tx_byte_i[ch*8 +: 8] = tx;
      if (i == 1) tx_byte_i[ch*8 +: 8] = tx_late;  // R9: late change ignored
      bit_stb_i = 1'b1; slot_vld_i = 2'(1 << ch); rx_data_i = rx[i];
      reg_we_i = (i == wr_at); reg_wdata_i = wr_val;
      #1;
      chk("R3", "strobe", sd_o, 1 << ch);
      if (m[i]) begin
        chk("R5", "rx_cap", rx_cap_o, 1);
        chk("R5", "tx_drv", tx_drv_o, 1);
        chk("R5", "tx_data", tx_data_o, tx[k]);
        k++; exp_rx[n] = rx[i]; n++; last_c = cyc;
      end else begin
        chk("R4", "rx_cap", rx_cap_o, 0);
        chk("R4", "tx_drv", tx_drv_o, 0);
        chk("R4", "tx_data", tx_data_o, 1);
      end
      if (i == 3) begin
        @(negedge clk_i); bit_stb_i = 1'b0; reg_we_i = 1'b0;
        #1;
        chk("R3", "strobe gap", sd_o, 1 << ch);
        chk("R3", "cap in gap", rx_cap_o, 0);
      end
    end
    @(negedge clk_i); bit_stb_i = 1'b0; slot_vld_i = '0; reg_we_i = 1'b0; rx_data_i = 1'b0;
    @(negedge clk_i); #1;
    if (n > 0) begin
      chk("R6", "valid count", v_cnt - v0, 1);
      chk("R6", "byte", v_byte, exp_rx);
      chk("R6", "len", v_len, n);
      chk("R2", "channel", v_ch, ch);
      chk("R6", "valid cycle", v_cyc, last_c + 1);
    end else begin
      chk("R7", "no valid", v_cnt - v0, 0);
    end
    if (wr_at >= 0) model = wr_val;
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1", "reset mask", reg_rdata_o, 16'hFFFF);
    chk("R3", "reset strobe", sd_o, 0);
    chk("R4", "reset tx idle", tx_data_o, 1);
    chk("R6", "reset valid", rx_valid_o, 0);
    rst_ni = 1'b1;
  endtask

  task automatic test_readback();
    write_mask(16'h3C96);
    write_mask(16'hFFFF);
  endtask

  task automatic test_full_mask();  // R2 R5 R6
    run_slot(0, 8'hA5, 8'h3C, -1, '0, 8'hA5);
    run_slot(1, 8'h0F, 8'hC3, -1, '0, 8'hF0);
  endtask

  task automatic test_sparse();  // R4 R5 R9
    write_mask(16'h815A);
    run_slot(0, 8'h6D, 8'hB2, -1, '0, 8'h92);
    run_slot(1, 8'h03, 8'h81, -1, '0, 8'hFC);
  endtask

  task automatic test_zero_byte();  // R7 R2 early completion
    write_mask(16'h0F00);
    run_slot(0, 8'hFF, 8'hFF, -1, '0, 8'h00);
    run_slot(1, 8'h0A, 8'h05, -1, '0, 8'h55);
  endtask

  task automatic test_mask_switch();  // R8
    write_mask(16'h00FF);
    run_slot(0, 8'h5C, 8'hE7, 4, 16'h0101, 8'h5C);
    run_slot(0, 8'h01, 8'h01, -1, '0, 8'h00);
    run_slot(0, 8'hC6, 8'h39, 0, 16'hFFFF, 8'h39);
    run_slot(0, 8'h96, 8'h69, -1, '0, 8'h96);
    #1 chk("R8", "mask after slots", reg_rdata_o, 16'hFFFF);
  endtask

  initial begin
    #200000;
    chk("WD", "watchdog", 1, 0);
    finish_run();
  end

  initial begin
    test_reset();
    test_readback();
    test_full_mask();
    test_sparse();
    test_zero_byte();
    test_mask_switch();
    finish_run();
  end
endmodule